// File: doc/BRIEF.md
# Four-Bit Carry-Lookahead Adder/Subtracter

This block is a combinational arithmetic unit for two unsigned 4-bit operands. One mode input selects the operation. With the mode low the block returns the sum and a carry-out. With the mode high it returns the difference and a no-borrow flag.

Subtraction is done in two's complement. The mode bit is XORed into every bit of the second operand, and the same bit is fed in as the carry-in. The first operand reaches the adder core unchanged in both modes.

Carries are not chained from one bit to the next. Each carry is a flat two-level sum of products over per-bit generate (AND) and propagate (OR) terms and the carry-in, so the carry depth does not grow with bit position. The unit has no clock and no state. Its outputs follow its present inputs.

Top module: `lac_addsub`

## Requirements
- R1: With `sub_mode` = 0, the concatenation {`carry_out`, `sum_out`} equals `a_in` + `b_in` as a 5-bit unsigned value.
- R2: With `sub_mode` = 1, `sum_out` equals (`a_in` − `b_in`) modulo 16.
- R3: With `sub_mode` = 1, `carry_out` is 1 when `a_in` ≥ `b_in` (no borrow) and 0 when `a_in` < `b_in` (borrow).
- R4: With `sub_mode` = 0, `carry_out` is 1 exactly when `a_in` + `b_in` ≥ 16.
- R5: `a_in` reaches the core unchanged. With `b_in` = 0 in add mode, `sum_out` = `a_in` and `carry_out` = 0.
- R6: In subtract mode with `b_in` = 0, the inverted operand is all ones and the injected carry-in travels through every propagate term, so `sum_out` = `a_in` and `carry_out` = 1.
- R7: The block holds no state. After an input change the outputs settle to the new result with no clock edge between the change and the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 4 | First operand (minuend in subtract mode) |
| b_in | input | 4 | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| sum_out | output | 4 | Sum or difference, modulo 16 |
| carry_out | output | 1 | Carry-out; in subtract mode, 1 means no borrow |

## Verification
The checker compares both outputs against a plain arithmetic model every time any input changes. This covers the sum and carry in add mode, the wrapped difference and the borrow flag in subtract mode, and the equal-operand case. These properties cannot show that the outputs settle with no clock edge between stimulus and check. Only the bench's back-to-back vectors inside one half clock period show that. The two zero-subtrahend corners also rely on the bench's directed checks, alongside the full sweep of all 512 operand and mode combinations.

// File: rtl/lac_pkg.sv
package lac_pkg;

    localparam int OPW = 4;
    localparam int RESW = OPW + 1;

    typedef logic [OPW-1:0] nib_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // Operands as seen by the adder core after mode conditioning
    typedef struct packed {
        nib_t x;
        nib_t y;
        logic cin;
    } core_in_t;

    // Per-bit carry terms
    typedef struct packed {
        nib_t p;
        nib_t g;
    } pg_t;

    // Carry vector: index 0 is carry-in, index OPW is carry-out
    typedef logic [OPW:0] carry_t;

endpackage

// File: rtl/lac_mode_cond.sv
module lac_mode_cond
    import lac_pkg::*;
(
    input  nib_t     opa,
    input  nib_t     opb,
    input  op_e      op,
    output core_in_t core
);
    logic inv;
    assign inv = (op == OP_SUB);

    assign core.x = opa;
    assign core.cin = inv;

    for (genvar i = 0; i < OPW; i++) begin : g_cond
        assign core.y[i] = opb[i] ^ inv;
    end
endmodule

// File: rtl/lac_pg_gen.sv
module lac_pg_gen
    import lac_pkg::*;
(
    input  core_in_t core,
    output pg_t      pg
);
    for (genvar i = 0; i < OPW; i++) begin : g_bit
        assign pg.p[i] = core.x[i] | core.y[i];
        assign pg.g[i] = core.x[i] & core.y[i];
    end
endmodule

// File: rtl/lac_carry_la.sv
module lac_carry_la
    import lac_pkg::*;
(
    input  pg_t    pg,
    input  logic   cin,
    output carry_t c
);
    logic [OPW-1:0] p;
    logic [OPW-1:0] g;

    assign p = pg.p;
    assign g = pg.g;

    // Every carry is a flat sum of products; none depends on another carry.
    assign c[0] = cin;
    assign c[1] = g[0]
                | (p[0] & cin);
    assign c[2] = g[1]
                | (p[1] & g[0])
                | (p[1] & p[0] & cin);
    assign c[3] = g[2]
                | (p[2] & g[1])
                | (p[2] & p[1] & g[0])
                | (p[2] & p[1] & p[0] & cin);
    assign c[4] = g[3]
                | (p[3] & g[2])
                | (p[3] & p[2] & g[1])
                | (p[3] & p[2] & p[1] & g[0])
                | (p[3] & p[2] & p[1] & p[0] & cin);
endmodule

// File: rtl/lac_addsub.sv
module lac_addsub
    import lac_pkg::*;
(
    input  logic [3:0] a_in,
    input  logic [3:0] b_in,
    input  logic       sub_mode,
    output logic [3:0] sum_out,
    output logic       carry_out
);
    core_in_t core;
    pg_t      pg;
    carry_t   cy;
    op_e      op;

    assign op = op_e'(sub_mode);

    lac_mode_cond u_cond (
        .opa  (a_in),
        .opb  (b_in),
        .op   (op),
        .core (core)
    );

    lac_pg_gen u_pg (
        .core (core),
        .pg   (pg)
    );

    lac_carry_la u_cla (
        .pg  (pg),
        .cin (core.cin),
        .c   (cy)
    );

    for (genvar i = 0; i < OPW; i++) begin : g_sum
        assign sum_out[i] = core.x[i] ^ core.y[i] ^ cy[i];
    end

    assign carry_out = cy[OPW];
endmodule

// File: rtl/lac_addsub_chk.sv
module lac_addsub_chk (
    input logic [3:0] a_in,
    input logic [3:0] b_in,
    input logic       sub_mode,
    input logic [3:0] sum_out,
    input logic       carry_out
);
    logic [4:0] ref_add;
    logic [3:0] ref_diff;

    assign ref_add  = {1'b0, a_in} + {1'b0, b_in};
    assign ref_diff = a_in - b_in;

    always_comb begin
        if (!$isunknown({a_in, b_in, sub_mode, sum_out, carry_out})) begin
            if (!sub_mode) begin
                p_add_sum_r1: assert ({carry_out, sum_out} == ref_add);
                p_add_carry_r4: assert (carry_out == (ref_add >= 5'd16));
            end else begin
                p_sub_diff_r2: assert (sum_out == ref_diff);
                p_no_borrow_r3: assert (carry_out == (a_in >= b_in));
                if (a_in == b_in) begin
                    p_equal_zero_r2: assert (sum_out == 4'd0 && carry_out);
                end
            end
        end
    end
endmodule

bind lac_addsub lac_addsub_chk u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .sub_mode  (sub_mode),
    .sum_out   (sum_out),
    .carry_out (carry_out)
);

// File: tb/lac_addsub_test.sv
module lac_addsub_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic       sub_mode = 1'b0;
    logic [3:0] sum_out;
    logic       carry_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lac_addsub uut (
        .a_in      (a_in),
        .b_in      (b_in),
        .sub_mode  (sub_mode),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d m=%0d)",
                     tag, act, exp, a_in, b_in, sub_mode);
        end
    endtask

    task automatic apply(input logic m, input logic [3:0] a, input logic [3:0] b);
        sub_mode = m;
        a_in = a;
        b_in = b;
        #1;
    endtask

    task automatic check_vec();
        int ai;
        int bi;
        int exp_sum;
        int exp_co;
        ai = int'(a_in);
        bi = int'(b_in);
        if (!sub_mode) begin
            exp_sum = (ai + bi) % 16;
            exp_co  = (ai + bi >= 16) ? 1 : 0;
            check(int'(sum_out) == exp_sum, "R1 add sum", int'(sum_out), exp_sum);
            check(int'(carry_out) == exp_co, "R4 add carry", int'(carry_out), exp_co);
        end else begin
            exp_sum = (ai - bi + 16) % 16;
            exp_co  = (ai >= bi) ? 1 : 0;
            check(int'(sum_out) == exp_sum, "R2 sub diff", int'(sum_out), exp_sum);
            check(int'(carry_out) == exp_co, "R3 no-borrow flag", int'(carry_out), exp_co);
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Idle state with zero inputs (R5)
        apply(1'b0, 4'd0, 4'd0);
        check(sum_out == 4'd0, "R5 idle sum", int'(sum_out), 0);
        check(carry_out == 1'b0, "R5 idle carry", int'(carry_out), 0);

        // R5: a passes through with b = 0 in add mode
        for (int a = 0; a < 16; a++) begin
            apply(1'b0, 4'(a), 4'd0);
            check(int'(sum_out) == a, "R5 pass-through sum", int'(sum_out), a);
            check(carry_out == 1'b0, "R5 pass-through carry", int'(carry_out), 0);
        end

        // R6: subtract zero, carry-in must cross every propagate term
        for (int a = 0; a < 16; a++) begin
            apply(1'b1, 4'(a), 4'd0);
            check(int'(sum_out) == a, "R6 minus-zero sum", int'(sum_out), a);
            check(carry_out == 1'b1, "R6 minus-zero carry", int'(carry_out), 1);
        end

        // R7: two vectors inside one half period, no clock edge between
        @(posedge clk);
        #1;
        apply(1'b0, 4'd15, 4'd1);
        check(sum_out == 4'd0 && carry_out, "R7 first vector", int'({carry_out, sum_out}), 16);
        apply(1'b1, 4'd3, 4'd9);
        check(sum_out == 4'd10 && !carry_out, "R7 second vector", int'({carry_out, sum_out}), 10);

        // Exhaustive sweep: R1, R2, R3, R4
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    @(negedge clk);
                    apply(1'(m), 4'(a), 4'(b));
                    check_vec();
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule